// File: doc/BRIEF.md
# Interrupt Merge Controller

The block gathers a set of interrupt request lines and folds them into one interrupt output. Each line passes through its own conditioning cell: a polarity bit chooses whether the line is active high or active low, and a kind bit chooses whether the line is treated as a level or as an edge. In edge mode, an active edge sets a sticky pending bit that stays set until software clears it by writing a one to it. In level mode, the status bit simply follows the conditioned line.

A per-line enable mask gates the status bits before they are ORed into the output. The output is registered, so it reacts one clock after the gated status changes. The enable mask can be written as a whole, or changed one bit at a time through separate set and clear write ports. A small word-addressed register bus with combinational read data gives access to every register. Two read-only words identify the controller: a fixed identity value, and an options word that holds the number of lines built.

All request lines are assumed to be synchronous to `clk`. Lines from another clock domain have to be synchronised before they reach the block.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After reset, the polarity, kind and enable registers read 0, every status bit reads 0 while the lines are low, and `irq_out` is 0.
- R2: Polarity register (word 0), bit i: 0 makes line i active high, 1 makes it active low. The conditioned line is the raw line XOR the polarity bit.
- R3: Kind register (word 1), bit i = 0 selects level mode. In level mode, status bit i (status register, word 6) equals the conditioned line. A write of 1 to acknowledge register word 5 has no effect on it.
- R4: Kind bit i = 1 selects edge mode. A 0-to-1 change of the conditioned line sets status bit i, and the bit stays set after the line returns to inactive.
- R5: A write to word 5 clears the edge status bits written as 1 and leaves the others unchanged. If a new active edge arrives in the same cycle as the acknowledge, the bit stays set.
- R6: Word 2 loads the whole enable mask and reads it back. A write to word 3 sets the enable bits written as 1. A write to word 4 clears the enable bits written as 1. Words 3 and 4 read back the enable mask.
- R7: `irq_out` is 1 exactly one cycle after any status bit whose enable bit is 1 is set. Word 7 reads status AND enable.
- R8: Word 9 reads the number of lines in bits 5:0 and 0 above them; that number must lie in 1..32. Word 8 reads the constant 0x02307A5E. Writes to either word have no effect.
- R9: Setting a line's kind bit to level discards its edge pending bit, so switching back to edge mode starts with status 0.
- R10: Register bits at or above the number of lines read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | NUM_SRC | Raw interrupt request lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, qualified by bus_sel |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Merged, registered interrupt output |

## Verification
The bench drives every line of an eight-line build through all four combinations of polarity and kind. Each run raises the line, drops it, and then acknowledges it. Level and edge modes differ in what happens after the line drops, and a correct polarity shows up as no status while the line is idle. The bench then holds a fixed level pattern and sweeps all 256 enable masks. This checks that `irq_out` and the gated status word depend on the AND of status and enable and on nothing else. Separate cases cover an acknowledge that arrives together with a new edge, level-mode acknowledge, the switch from edge to level mode, enable set/clear, and writes to the read-only and unimplemented bits.

// File: rtl/irq_merge_pkg.sv
// Package: register word addresses and constants shared by the
// interrupt merge controller and its bench.
package irq_merge_pkg;
    localparam int ADDR_W = 4;
    localparam int WORD_W = 32;

    localparam logic [ADDR_W-1:0] A_POLARITY = 4'd0;
    localparam logic [ADDR_W-1:0] A_KIND     = 4'd1;
    localparam logic [ADDR_W-1:0] A_EN_LOAD  = 4'd2;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 4'd3;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 4'd4;
    localparam logic [ADDR_W-1:0] A_ACK      = 4'd5;
    localparam logic [ADDR_W-1:0] A_STATUS   = 4'd6;
    localparam logic [ADDR_W-1:0] A_ACTIVE   = 4'd7;
    localparam logic [ADDR_W-1:0] A_IDENT    = 4'd8;
    localparam logic [ADDR_W-1:0] A_OPTIONS  = 4'd9;

    // Identity word: bits 27:20 and 15:0 carry the controller identity.
    localparam logic [WORD_W-1:0] IDENT_WORD = 32'h0230_7A5E;
endpackage

// File: rtl/irq_src_cell.sv
// Module: irq_src_cell
// Conditions one request line. It applies the polarity, detects the active
// edge, and keeps a sticky pending bit in edge mode.
// Assumes line_i is synchronous to clk. The pending bit is cleared while
// the cell is in level mode. A new edge wins over an acknowledge that
// arrives in the same cycle.
module irq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic pol_i,
    input  logic edge_i,
    input  logic ack_i,
    output logic status_o
);
    logic adj;
    logic adj_prev_q;
    logic pend_q;
    logic rise;

    // Polarity-adjust the line and detect a 0-to-1 change of it.
    always_comb begin
        adj  = line_i ^ pol_i;
        rise = adj & ~adj_prev_q;
    end

    // Remember the adjusted line from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) adj_prev_q <= 1'b0;
        else        adj_prev_q <= adj;
    end

    // Keep the sticky pending bit: set on an edge, clear on acknowledge, drop in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (!edge_i) pend_q <= 1'b0;
        else             pend_q <= (pend_q & ~ack_i) | rise;
    end

    // Choose what this line reports as its status.
    always_comb status_o = edge_i ? pend_q : adj;

    assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && pend_q && !ack_i) |=> pend_q);
    assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && rise) |=> pend_q);
    assert_level_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_i |=> !pend_q);
endmodule

// File: rtl/irq_enable_bank.sv
// Module: irq_enable_bank
// Holds the per-line enable mask. The mask can be loaded as a whole, or
// changed bit by bit with write-one-to-set and write-one-to-clear ports.
// Assumes that at most one of the three write strobes is high in a cycle.
module irq_enable_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               set_i,
    input  logic               clr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] en_o
);
    logic [NUM_SRC-1:0] en_q;

    // Apply whichever enable write is strobed this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (load_i) en_q <= wdata_i;
        else if (set_i)  en_q <= en_q | wdata_i;
        else if (clr_i)  en_q <= en_q & ~wdata_i;
    end

    assign en_o = en_q;

    assert_en_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
    assert_en_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((en_q & $past(wdata_i)) == '0));
    assert_en_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i || set_i || clr_i) |=> $stable(en_q));
endmodule

// File: rtl/irq_merge_ctrl.sv
// Module: irq_merge_ctrl (top)
// Merges NUM_SRC request lines into one registered interrupt output.
// Contains the register decode, the polarity and kind registers, one
// conditioning cell per line, and the enable bank.
// Assumes: NUM_SRC is in 1..32, the lines are synchronous to clk, and read
// data is valid in the same cycle that bus_addr is presented.
module irq_merge_ctrl
    import irq_merge_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_lines,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               irq_out
);
    localparam logic [5:0] COUNT_FIELD = 6'(NUM_SRC);

    logic [NUM_SRC-1:0] pol_q;
    logic [NUM_SRC-1:0] kind_q;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] status_vec;
    logic [NUM_SRC-1:0] active_vec;
    logic [NUM_SRC-1:0] wbits;
    logic               wr_pol, wr_kind, wr_load, wr_set, wr_clr, wr_ack;
    logic               irq_q;

    // Decode the write strobes from the bus.
    always_comb begin
        wbits   = bus_wdata[NUM_SRC-1:0];
        wr_pol  = bus_sel && bus_wr && (bus_addr == A_POLARITY);
        wr_kind = bus_sel && bus_wr && (bus_addr == A_KIND);
        wr_load = bus_sel && bus_wr && (bus_addr == A_EN_LOAD);
        wr_set  = bus_sel && bus_wr && (bus_addr == A_EN_SET);
        wr_clr  = bus_sel && bus_wr && (bus_addr == A_EN_CLR);
        wr_ack  = bus_sel && bus_wr && (bus_addr == A_ACK);
    end

    // Hold the polarity and kind configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            kind_q <= '0;
        end else begin
            if (wr_pol)  pol_q  <= wbits;
            if (wr_kind) kind_q <= wbits;
        end
    end

    // One conditioning cell for each line.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_i   (irq_lines[g]),
            .pol_i    (pol_q[g]),
            .edge_i   (kind_q[g]),
            .ack_i    (wr_ack & wbits[g]),
            .status_o (status_vec[g])
        );
    end

    irq_enable_bank #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (wr_load),
        .set_i   (wr_set),
        .clr_i   (wr_clr),
        .wdata_i (wbits),
        .en_o    (en_vec)
    );

    // Gate the status with the enables.
    always_comb active_vec = status_vec & en_vec;

    // Register the OR of the gated status as the merged output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |active_vec;
    end

    assign irq_out = irq_q;

    // Zero-extend a per-line vector to a bus word.
    function automatic logic [WORD_W-1:0] widen(input logic [NUM_SRC-1:0] v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[NUM_SRC-1:0] = v;
        return w;
    endfunction

    // Select the read data for the addressed word.
    always_comb begin
        case (bus_addr)
            A_POLARITY: bus_rdata = widen(pol_q);
            A_KIND:     bus_rdata = widen(kind_q);
            A_EN_LOAD,
            A_EN_SET,
            A_EN_CLR:   bus_rdata = widen(en_vec);
            A_STATUS:   bus_rdata = widen(status_vec);
            A_ACTIVE:   bus_rdata = widen(active_vec);
            A_IDENT:    bus_rdata = IDENT_WORD;
            A_OPTIONS:  bus_rdata = {26'd0, COUNT_FIELD};
            default:    bus_rdata = '0;
        endcase
    end

    initial begin
        assert_count_range_R8: assert (NUM_SRC >= 1 && NUM_SRC <= 32);
    end

    assert_out_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(status_vec & en_vec))));
    assert_pol_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pol |=> $stable(pol_q));
endmodule

// File: tb/irq_merge_ctrl_tb.sv
// Bench: sweeps every line of an 8-line build through all polarity and kind
// combinations, then sweeps all enable masks. Expected values are computed
// in the bench from the requirements.
module irq_merge_ctrl_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] lines = '0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_out;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    irq_merge_ctrl #(.NUM_SRC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [7:0]  pat;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(4'd0, v); check("R1 polarity", v, 0);
        rd(4'd1, v); check("R1 kind", v, 0);
        rd(4'd2, v); check("R1 enable", v, 0);
        rd(4'd6, v); check("R1 status", v, 0);
        check("R1 irq_out", {31'd0, irq_out}, 0);

        // R8 identity and options, writes ignored
        wr(4'd8, 32'hFFFF_FFFF); wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd8, v); check("R8 ident", v, 32'h0230_7A5E);
        rd(4'd9, v); check("R8 options", v, N);

        // R2/R3/R4/R5/R7 sweep every line, polarity and kind
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [7:0] bit_m;
                    bit_m = 8'(1 << i);
                    wr(4'd1, 0);
                    wr(4'd2, 0);
                    lines = p ? bit_m : 8'h00;
                    wr(4'd0, p ? 32'(bit_m) : 0);
                    wr(4'd1, k ? 32'(bit_m) : 0);
                    wr(4'd5, 32'hFF);
                    wr(4'd2, 32'(bit_m));
                    idle(2);
                    rd(4'd6, v); check("R2 idle status", v, 0);
                    check("R7 idle out", {31'd0, irq_out}, 0);
                    lines = lines ^ bit_m;
                    idle(2);
                    rd(4'd6, v); check(k ? "R4 edge active" : "R2 level active", v, 32'(bit_m));
                    check("R7 out active", {31'd0, irq_out}, 1);
                    lines = lines ^ bit_m;
                    idle(2);
                    rd(4'd6, v);
                    check(k ? "R4 edge sticky" : "R3 level release", v, k ? 32'(bit_m) : 0);
                    check("R7 out after release", {31'd0, irq_out}, 32'(k));
                    wr(4'd5, 32'(bit_m));
                    idle(2);
                    rd(4'd6, v); check("R5 after ack", v, 0);
                    check("R7 out after ack", {31'd0, irq_out}, 0);
                end
            end
        end

        // Reconfigure: all level, active high, lines idle
        wr(4'd0, 0); wr(4'd1, 0); wr(4'd2, 0); lines = '0; idle(2);

        // R3 acknowledge has no effect on an active level line
        lines = 8'h04; wr(4'd5, 32'hFF); idle(1);
        rd(4'd6, v); check("R3 level ack ignored", v, 32'h04);
        lines = '0;

        // R5 acknowledge and a new edge in the same cycle: the edge wins
        wr(4'd1, 32'h01); wr(4'd2, 32'h01);
        lines = 8'h01; idle(2); lines = 8'h00; idle(1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd5; bus_wdata = 32'h01;
        lines = 8'h01;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(4'd6, v); check("R5 edge wins over ack", v, 32'h01);
        // R5 acknowledge clears only the bits written as 1
        wr(4'd5, 32'hFE); rd(4'd6, v); check("R5 unwritten bits kept", v, 32'h01);
        lines = 8'h00;

        // R9 switching to level mode drops the pending bit
        wr(4'd1, 0); wr(4'd1, 32'h01); idle(1);
        rd(4'd6, v); check("R9 pending dropped", v, 0);
        wr(4'd1, 0);

        // R6 enable load, set, clear
        wr(4'd2, 32'h3C); rd(4'd2, v); check("R6 load", v, 32'h3C);
        wr(4'd3, 32'h81); rd(4'd3, v); check("R6 set", v, 32'hBD);
        wr(4'd4, 32'h0C); rd(4'd4, v); check("R6 clear", v, 32'hB1);

        // R10 bits above the line count
        wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, v); check("R10 polarity width", v, 32'hFF);
        wr(4'd0, 0);

        // R7 enable sweep with a fixed level pattern
        pat = 8'hA5; lines = pat;
        for (int e = 0; e < 256; e++) begin
            wr(4'd2, 32'(e));
            idle(1);
            rd(4'd7, v); check("R7 active word", v, 32'(pat & 8'(e)));
            check("R7 merged out", {31'd0, irq_out}, {31'd0, |(pat & 8'(e))});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule